// File: doc/BRIEF.md
# Two-Class Round-Robin Output Arbiter

This block owns one output port of an 11-port packet switch. Every source port of the switch raises a request line toward this output and tags it with a one-bit class: urgent or normal. The arbiter gives the output to exactly one source through a one-hot grant vector. It keeps that grant until the granted source pulses end-of-packet, so each packet crosses the switch without interruption.

At each arbitration point, an urgent request beats every normal request. Inside each class a separate rotating pointer makes the choice. The pointer starts its scan just past that class's previous winner, so sources in the same class take equal turns. A lone requester is granted on the next clock edge. The same edge that takes the end-of-packet pulse can hand the output directly to the next winner, so the port does not go idle between packets.

The crossbar data path and the choice among several candidate outputs are handled by other blocks.

Top module: `prio_out_arbiter`

## Requirements
- R1: `grant` is one-hot or all zeros in every cycle.
- R2: An arbitration point is any cycle in which `grant` is all zeros, or in which `pkt_end` is high. If any `req` bit is high at such a point, the next cycle's `grant` is the one-hot code of one of those requesters. A single requester is granted on the first edge after it raises its request.
- R3: At an arbitration point where any source has both `req[i]` and `req_hi[i]` high, the grant goes to one of those sources and never to a source whose `req_hi` bit is low.
- R4: While `grant` is nonzero and `pkt_end` is low, `grant` stays unchanged whatever `req` and `req_hi` do, including new urgent requests.
- R5: A cycle with `pkt_end` high ends the current grant. The next cycle's `grant` is the winner of the requests present in that cycle, or all zeros if there are none.
- R6: Urgent class: the winner is the first urgent requester found by scanning upward in index order, wrapping from N-1 to 0, starting at the urgent pointer. After an urgent win, that pointer becomes the winner index plus one, modulo N.
- R7: Normal class: the same scan is done over normal requesters with a separate normal pointer. The normal pointer moves only on a normal win; an urgent win leaves it unchanged.
- R8: At an arbitration point with no requests, `grant` becomes all zeros and both pointers keep their values.
- R9: `pkt_end` has no effect while `grant` is all zeros.
- R10: Reset (`rst_n` low at a clock edge) clears `grant` and sets both pointers to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_SRC | Request from each source port |
| req_hi | input | N_SRC | Class of each request: 1 urgent, 0 normal |
| pkt_end | input | 1 | End-of-packet pulse from the granted source |
| grant | output | N_SRC | One-hot grant, all zeros when the output is free |

## Verification
The bench sends an urgent request into the middle of a normal packet. A design that pre-empts the packet would switch the grant before `pkt_end`.

It runs repeated urgent requests from several sources, including the wrap from index 10 back to 0. A pointer that advanced from the wrong place or failed to wrap would repeat or skip a source.

It lets urgent packets win while normal requests are held back, then checks which normal source wins next. A shared or disturbed normal pointer would pick the wrong source.

It also pulses `pkt_end` while the output is free and inserts idle arbitration points. A design that moved its pointers at those points would drift away from the bench model in later choices.

// File: rtl/arb_pkg.sv
// Shared definitions for the two-class output arbiter.
// Assumes: class index 1 is urgent, class index 0 is normal.
package arb_pkg;
    localparam int N_CLASS = 2;
    localparam int CLS_NORMAL = 0;
    localparam int CLS_URGENT = 1;

    // Index following idx in a ring of n positions.
    function automatic int ring_next(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/rr_picker.sv
// Combinational round-robin picker.
// Scans cand upward from start_ptr, wrapping at N, and reports the first set bit.
// Assumes start_ptr < N.
module rr_picker #(
    parameter int N  = 11,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] start_ptr,
    output logic [N-1:0]  win_oh,
    output logic [IW-1:0] win_idx,
    output logic          win_any
);
    // Find the first candidate at or after the pointer.
    always_comb begin
        win_oh  = '0;
        win_idx = '0;
        win_any = 1'b0;
        for (int off = 0; off < N; off++) begin
            int pos;
            pos = int'(start_ptr) + off;
            if (pos >= N) pos = pos - N;
            if (!win_any && cand[pos]) begin
                win_any      = 1'b1;
                win_idx      = IW'(pos);
                win_oh[pos]  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rr_pointer.sv
// Per-class rotating pointer.
// On advance it moves to one past the winning index; otherwise it holds.
// Assumes win_idx < N whenever advance is high.
module rr_pointer #(
    parameter int N  = 11,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic [IW-1:0] win_idx,
    output logic [IW-1:0] ptr
);
    import arb_pkg::*;

    // Pointer register: reset to 0, move past the winner on a win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= IW'(ring_next(int'(win_idx), N));
        end
    end

    // Without a win in this class the pointer must not move.
    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr));

    assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < N);
endmodule

// File: rtl/prio_out_arbiter.sv
// Output-port arbiter with two request classes.
// Urgent requests beat normal ones; each class rotates fairly with its own pointer.
// A grant is held from the arbitration point until the owner pulses pkt_end.
// Assumes pkt_end comes only from the granted source; it is ignored while idle.
module prio_out_arbiter #(
    parameter int N_SRC = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] req_hi,
    input  logic             pkt_end,
    output logic [N_SRC-1:0] grant
);
    import arb_pkg::*;

    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic             arb_en;
    logic [N_CLASS-1:0] cls_any;
    logic [N_CLASS-1:0] cls_adv;
    logic [N_SRC-1:0] cls_oh  [N_CLASS];
    logic [IW-1:0]    cls_idx [N_CLASS];
    logic [IW-1:0]    cls_ptr [N_CLASS];
    logic             urgent_sel;
    logic [N_SRC-1:0] next_grant;

    // Arbitrate when the output is free or the current packet is ending.
    always_comb arb_en = (grant == '0) || pkt_end;

    // Urgent class wins whenever it has any candidate.
    always_comb urgent_sel = cls_any[CLS_URGENT];

    // One picker and one pointer per class.
    for (genvar c = 0; c < N_CLASS; c++) begin : g_class
        logic [N_SRC-1:0] cand;

        // Candidates of this class.
        always_comb cand = (c == CLS_URGENT) ? (req & req_hi) : (req & ~req_hi);

        rr_picker #(.N(N_SRC), .IW(IW)) i_pick (
            .cand      (cand),
            .start_ptr (cls_ptr[c]),
            .win_oh    (cls_oh[c]),
            .win_idx   (cls_idx[c]),
            .win_any   (cls_any[c])
        );

        // Advance only when this class supplies the winner.
        always_comb cls_adv[c] = arb_en && cls_any[c] &&
                                 ((c == CLS_URGENT) ? 1'b1 : !urgent_sel);

        rr_pointer #(.N(N_SRC), .IW(IW)) i_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .advance (cls_adv[c]),
            .win_idx (cls_idx[c]),
            .ptr     (cls_ptr[c])
        );
    end

    // Winner of this arbitration point, or none.
    always_comb next_grant = urgent_sel ? cls_oh[CLS_URGENT] : cls_oh[CLS_NORMAL];

    // Grant register: load at arbitration points, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= '0;
        end else if (arb_en) begin
            grant <= next_grant;
        end
    end

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && (req != '0)) |=> ((grant & $past(req)) != '0));

    assert_urgent_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && ((req & req_hi) != '0)) |=> ((grant & $past(req & req_hi)) != '0));

    assert_hold_packet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && !pkt_end) |=> (grant == $past(grant)));

    assert_no_req_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && (req == '0)) |=> (grant == '0));

    assert_one_class_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cls_adv[CLS_URGENT] && cls_adv[CLS_NORMAL]));
endmodule

// File: tb/test_prio_out_arbiter.sv
module test_prio_out_arbiter;
    localparam int N = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] req_hi = '0;
    logic         pkt_end = 1'b0;
    logic [N-1:0] grant;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [N-1:0] exp_grant = '0;
    int hp = 0;
    int lp = 0;

    always #2 clk = ~clk;

    prio_out_arbiter #(.N_SRC(N)) i_prio_out_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .req_hi(req_hi),
        .pkt_end(pkt_end), .grant(grant)
    );

    function automatic int pick(input logic [N-1:0] m, input int p);
        for (int off = 0; off < N; off++) begin
            int k;
            k = (p + off) % N;
            if (m[k]) return k;
        end
        return -1;
    endfunction

    // Reference model of one clock edge, from the requirements.
    task automatic model_edge();
        if (!rst_n) begin
            exp_grant = '0; hp = 0; lp = 0;
        end else if (exp_grant == '0 || pkt_end) begin
            int w;
            if ((req & req_hi) != '0) begin
                w = pick(req & req_hi, hp);
                exp_grant = '0; exp_grant[w] = 1'b1; hp = (w + 1) % N;
            end else if (req != '0) begin
                w = pick(req & ~req_hi, lp);
                exp_grant = '0; exp_grant[w] = 1'b1; lp = (w + 1) % N;
            end else begin
                exp_grant = '0;
            end
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if (grant !== exp_grant) begin
            fails++;
            $display("FAIL %s: grant actual=%b expected=%b", tag, grant, exp_grant);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic [N-1:0] h,
                        input logic pe, input string tag);
        req = r; req_hi = h; pkt_end = pe;
        @(posedge clk);
        model_edge();
        #1 check(tag);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) begin
            @(posedge clk);
            model_edge();
        end
        #1 check("R10 reset");
        rst_n = 1'b1;

        // Lone normal requester.
        step(11'b000_0000_1000, '0, 1'b0, "R2 single requester");
        // Urgent request mid-packet must not pre-empt.
        step(11'b000_0000_1001, 11'b000_0000_0001, 1'b0, "R4 no preempt");
        step(11'b000_0000_1001, 11'b000_0000_0001, 1'b0, "R4 still held");
        // Packet ends: urgent source 0 beats normal source 5.
        step(11'b000_0010_0001, 11'b000_0000_0001, 1'b1, "R3 urgent first");
        // Packet ends with no requests.
        step('0, '0, 1'b1, "R5 release to idle");
        // End pulse while idle is ignored.
        step('0, '0, 1'b1, "R9 idle end pulse");
        // Normal pointer untouched by the urgent win: expect source 6.
        step(11'b000_0100_0100, '0, 1'b0, "R7 normal pointer independent");
        // Back-to-back urgent rotation with wrap.
        step(11'b100_0000_0011, 11'b100_0000_0011, 1'b1, "R6 urgent rotation a");
        step(11'b100_0000_0011, 11'b100_0000_0011, 1'b1, "R6 urgent rotation b");
        step(11'b100_0000_0011, 11'b100_0000_0011, 1'b1, "R6 urgent wrap");
        step(11'b100_0000_0011, 11'b100_0000_0011, 1'b1, "R6 urgent rotation c");
        // Idle points then a normal choice, pointer must have held.
        step('0, '0, 1'b1, "R8 no requests");
        step('0, '0, 1'b0, "R8 idle hold");
        step(11'b000_1000_0100, '0, 1'b0, "R8 pointer kept");
        step(11'b000_1000_0100, '0, 1'b1, "R7 normal rotation");

        // Random mix.
        for (int i = 0; i < 4000; i++) begin
            logic [N-1:0] r;
            logic [N-1:0] h;
            logic pe;
            for (int b = 0; b < N; b++) begin
                r[b] = ($urandom % 100) < 30;
                h[b] = ($urandom % 100) < 30;
            end
            pe = ($urandom % 100) < ((exp_grant != '0) ? 25 : 10);
            step(r, h, pe, "R1 R3 R6 R7 random");
            if (!$onehot0(grant)) begin
                checks++; fails++;
                $display("FAIL R1: grant actual=%b expected=onehot0", grant);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule